// File: doc/BRIEF.md
# JPEG Marker Stream Parser

This block reads the byte stream of a baseline JPEG file after a start pulse. It first checks the start-of-image marker. It then walks the marker segments that follow and moves their contents out of the stream:

- Quantization tables and entropy code tables leave through a single table write port.
- Frame parameters are held in output registers.
- Segments the decoder does not need are stepped over by their length field.

When a scan header has been read, the parser stops reading and raises an ownership signal. The entropy decoder then takes the stream. When the decoder reports that it has reached the next marker, the parser resumes its marker search. An end-of-image marker returns the parser to idle with a one-cycle done pulse. Any fault stops the parser in idle with an error code. The code stays until the next start.

Top module: `jpegMarkerParser`

## Requirements
- R1: After reset, and after any return to idle, `inReady` is low and no byte is taken until a `startIn` pulse; `errCode` resets to 0 and no table write occurs.
- R2: The first two accepted bytes must be 0xFF then 0xD8; any other byte in either position sets `errCode` to 1 and returns the parser to idle.
- R3: While searching for a marker, bytes other than 0xFF are dropped, repeated 0xFF fill bytes are ignored, and the codes 0x00, 0x01 and 0xD0 through 0xD8 are taken as markers without a length field.
- R4: Every marker segment with a length field carries a 16-bit big-endian length that counts its own two bytes; segments of any unrecognised code are skipped by exactly that count, even when their payload contains 0xFF bytes.
- R5: Segment code 0xDB holds one or more quantization tables. Each table starts with a header byte whose upper nibble is the precision (only 0 is accepted; any other value sets `errCode` to 3) and whose bits [1:0] give the table id. The header is followed by 64 bytes written with `tblWrHuff`=0 at addresses 0 to 63.
- R6: Segment code 0xC4 holds one or more code tables. Each table starts with a header byte whose bit 4 gives the class and whose bits [1:0] give the id. Sixteen count bytes follow and are written at addresses 0 to 15. Then as many symbol bytes as the counts sum to are written from address 16 upward, all with `tblWrHuff`=1.
- R7: Segment code 0xC0 is a frame header, read as follows:
  - Its first byte must be 8, or `errCode` becomes 2.
  - Height and width follow as big-endian 16-bit values, then the component count.
  - Each component then has an id, a sampling byte and a selector byte. For the first NCOMP components, the sampling byte is stored in `compSamp` lane i and selector bits [1:0] in `compQsel` lane i.
- R8: Frame codes 0xC1-0xC3, 0xC5-0xC7, 0xC9-0xCB and 0xCD-0xCF (non-baseline processes) set `errCode` to 2 and return the parser to idle.
- R9: After the last byte of a segment with code 0xDA, `scanOwn` goes high and `inReady` goes low. They stay so until a `scanDone` pulse, after which the marker search resumes.
- R10: The marker 0xFF 0xD9 raises `doneOut` for exactly one cycle, leaves `errCode` at 0 and returns the parser to idle.
- R11: A table write appears on the port in the cycle after the clock edge that accepted its byte, with `tblWrEn` high for that one cycle.
- R12: A `startIn` pulse restarts parsing from the start-marker check from any state and clears `errCode`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| startIn | input | 1 | Start pulse; begins the start-marker check |
| inData | input | 8 | Stream byte |
| inValid | input | 1 | Stream byte present |
| inReady | output | 1 | Parser takes the byte this cycle |
| scanOwn | output | 1 | Entropy decoder owns the stream |
| scanDone | input | 1 | Pulse from the entropy decoder returning the stream |
| doneOut | output | 1 | One-cycle pulse on end of image |
| errCode | output | 2 | 0 none, 1 bad start marker, 2 unsupported frame, 3 bad table precision |
| tblWrEn | output | 1 | Table write strobe |
| tblWrHuff | output | 1 | 0 quantization table, 1 code table |
| tblWrCls | output | 1 | Code table class |
| tblWrId | output | 2 | Table id |
| tblWrAddr | output | 9 | Byte address within the table |
| tblWrData | output | 8 | Table byte |
| frmHeight | output | 16 | Image height |
| frmWidth | output | 16 | Image width |
| frmComps | output | 8 | Component count |
| compSamp | output | NCOMP*8 | Sampling byte per component, lane i at bits [8i+7:8i] |
| compQsel | output | NCOMP*2 | Quantization selector per component, lane i at bits [2i+1:2i] |

## Verification
A length counter that is off by one shifts the parser's view of the stream. The byte after the skipped segment is then misread as the first byte after a segment, so a false error code or a stray done pulse shows at the ports within the next few bytes. The bench therefore places 0xFF 0xD9 inside a skipped payload. A table index that runs one step too far or too short shows on the very next write as a wrong address, or as a missing or extra write strobe. Each stream byte is followed by a check of the write port, so the fault is reported on the cycle it occurs. A handoff state that leaks shows as `inReady` high while `scanOwn` is high.

// File: rtl/jpegParsePkg.sv
package jpegParsePkg;

  typedef enum logic [3:0] {
    S_IDLE, S_SOI0, S_SOI1, S_SEEK, S_MARK, S_LENH, S_LENL, S_SEGGO,
    S_SKIP, S_QHDR, S_QBODY, S_HHDR, S_HCNT, S_HSYM, S_FRAME, S_HAND
  } parseState_t;

  typedef enum logic [2:0] {K_SKIP, K_QUANT, K_HUFF, K_FRAME, K_SCAN} segKind_t;

  localparam logic [1:0] ERR_NONE  = 2'd0;
  localparam logic [1:0] ERR_SOI   = 2'd1;
  localparam logic [1:0] ERR_FRAME = 2'd2;
  localparam logic [1:0] ERR_PREC  = 2'd3;

  // strobes from control to datapath
  typedef struct packed {
    logic lenHi;
    logic lenLo;
    logic useByte;
    logic idxClr;
    logic idxInc;
    logic hdrQ;
    logic hdrH;
    logic cntByte;
    logic symByte;
    logic wrTbl;
    logic frmByte;
  } ctlStrb_t;

  // status from datapath to control
  typedef struct packed {
    logic        lastByte;
    logic        remZero;
    logic [8:0]  idx;
    logic [11:0] symLeft;
  } dpStat_t;

endpackage

// File: rtl/parserDp.sv
module parserDp
  import jpegParsePkg::*;
#(
  parameter int NCOMP = 4
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic [7:0]         inByte,
  input  ctlStrb_t           strb,
  output dpStat_t            st,
  output logic               tblWrEn,
  output logic               tblWrHuff,
  output logic               tblWrCls,
  output logic [1:0]         tblWrId,
  output logic [8:0]         tblWrAddr,
  output logic [7:0]         tblWrData,
  output logic [15:0]        frmHeight,
  output logic [15:0]        frmWidth,
  output logic [7:0]         frmComps,
  output logic [NCOMP*8-1:0] compSamp,
  output logic [NCOMP*2-1:0] compQsel
);
  localparam int CIW = (NCOMP > 1) ? $clog2(NCOMP) : 1;

  logic [15:0] remLen;
  logic [8:0]  idx;
  logic [11:0] symLeft;
  logic [7:0]  compI;
  logic [1:0]  sub;
  logic        compOk;

  assign compOk = 32'(compI) < NCOMP;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      remLen <= '0; idx <= '0; symLeft <= '0; compI <= '0; sub <= '0;
      tblWrEn <= 1'b0; tblWrHuff <= 1'b0; tblWrCls <= 1'b0; tblWrId <= '0;
      tblWrAddr <= '0; tblWrData <= '0;
      frmHeight <= '0; frmWidth <= '0; frmComps <= '0;
      compSamp <= '0; compQsel <= '0;
    end else begin
      if (strb.lenHi) remLen[15:8] <= inByte;
      if (strb.lenLo) remLen <= {remLen[15:8], inByte} - 16'd2;
      else if (strb.useByte) remLen <= remLen - 16'd1;

      if (strb.idxClr) idx <= '0;
      else if (strb.idxInc && idx != 9'h1FF) idx <= idx + 9'd1;

      if (strb.hdrQ) begin
        tblWrHuff <= 1'b0; tblWrCls <= 1'b0; tblWrId <= inByte[1:0];
      end
      if (strb.hdrH) begin
        tblWrHuff <= 1'b1; tblWrCls <= inByte[4]; tblWrId <= inByte[1:0];
        symLeft <= '0;
      end
      if (strb.cntByte) symLeft <= symLeft + {4'b0, inByte};
      if (strb.symByte) symLeft <= symLeft - 12'd1;

      tblWrEn <= strb.wrTbl;
      if (strb.wrTbl) begin
        tblWrAddr <= idx;
        tblWrData <= inByte;
      end

      if (strb.frmByte) begin
        case (idx)
          9'd0: ;
          9'd1: frmHeight[15:8] <= inByte;
          9'd2: frmHeight[7:0]  <= inByte;
          9'd3: frmWidth[15:8]  <= inByte;
          9'd4: frmWidth[7:0]   <= inByte;
          9'd5: begin frmComps <= inByte; compI <= '0; sub <= '0; end
          default: begin
            if (sub == 2'd1 && compOk) compSamp[compI[CIW-1:0]*8 +: 8] <= inByte;
            if (sub == 2'd2 && compOk) compQsel[compI[CIW-1:0]*2 +: 2] <= inByte[1:0];
            if (sub == 2'd2) begin
              sub <= '0;
              if (compI != 8'hFF) compI <= compI + 8'd1;
            end else begin
              sub <= sub + 2'd1;
            end
          end
        endcase
      end
    end
  end

  assign st.lastByte = (remLen == 16'd1);
  assign st.remZero  = (remLen == 16'd0);
  assign st.idx      = idx;
  assign st.symLeft  = symLeft;

  // R5
  quantAddrRange_chk: assert property (@(posedge clk) disable iff (!rstN)
    (tblWrEn && !tblWrHuff) |-> (tblWrAddr < 9'd64));

endmodule

// File: rtl/parserCtl.sv
module parserCtl
  import jpegParsePkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       startIn,
  input  logic       inValid,
  input  logic [7:0] inByte,
  input  logic       scanDone,
  input  dpStat_t    st,
  output logic       inReady,
  output logic       scanOwn,
  output logic       doneOut,
  output logic [1:0] errCode,
  output ctlStrb_t   strb
);
  parseState_t state, nxt;
  segKind_t    kind, kindNxt;
  logic [1:0]  errNxt;
  logic        doneNxt, acc, body;

  function automatic logic isAlone(input logic [7:0] b);
    return (b == 8'h00) || (b == 8'h01) || (b >= 8'hD0 && b <= 8'hD8);
  endfunction

  function automatic logic isBadSof(input logic [7:0] b);
    return (b[7:4] == 4'hC) && (b[1:0] != 2'b00 || b[3:2] == 2'b11)
           && (b != 8'hC4) && (b != 8'hC8) && (b != 8'hCC) && (b != 8'hC0);
  endfunction

  assign inReady = !(state inside {S_IDLE, S_SEGGO, S_HAND});
  assign scanOwn = (state == S_HAND);
  assign acc     = inValid && inReady;
  assign body    = state inside {S_SKIP, S_QHDR, S_QBODY, S_HHDR, S_HCNT, S_HSYM, S_FRAME};

  always_comb begin
    nxt = state; kindNxt = kind; errNxt = errCode; doneNxt = 1'b0; strb = '0;
    if (startIn) begin
      nxt = S_SOI0; errNxt = ERR_NONE;
    end else begin
      case (state)
        S_SOI0: if (acc) begin
          if (inByte == 8'hFF) nxt = S_SOI1;
          else begin nxt = S_IDLE; errNxt = ERR_SOI; end
        end
        S_SOI1: if (acc) begin
          if (inByte == 8'hD8) nxt = S_SEEK;
          else begin nxt = S_IDLE; errNxt = ERR_SOI; end
        end
        S_SEEK: if (acc && inByte == 8'hFF) nxt = S_MARK;
        S_MARK: if (acc) begin
          if (inByte == 8'hFF) nxt = S_MARK;
          else if (inByte == 8'hD9) begin nxt = S_IDLE; doneNxt = 1'b1; end
          else if (isAlone(inByte)) nxt = S_SEEK;
          else if (isBadSof(inByte)) begin nxt = S_IDLE; errNxt = ERR_FRAME; end
          else begin
            nxt = S_LENH;
            case (inByte)
              8'hC0:   kindNxt = K_FRAME;
              8'hC4:   kindNxt = K_HUFF;
              8'hDB:   kindNxt = K_QUANT;
              8'hDA:   kindNxt = K_SCAN;
              default: kindNxt = K_SKIP;
            endcase
          end
        end
        S_LENH: if (acc) begin strb.lenHi = 1'b1; nxt = S_LENL; end
        S_LENL: if (acc) begin strb.lenLo = 1'b1; nxt = S_SEGGO; end
        S_SEGGO: begin
          strb.idxClr = 1'b1;
          if (st.remZero) nxt = (kind == K_SCAN) ? S_HAND : S_SEEK;
          else begin
            case (kind)
              K_QUANT: nxt = S_QHDR;
              K_HUFF:  nxt = S_HHDR;
              K_FRAME: nxt = S_FRAME;
              default: nxt = S_SKIP;
            endcase
          end
        end
        S_HAND: if (scanDone) nxt = S_SEEK;
        S_QHDR: if (acc) begin
          if (inByte[7:4] != 4'h0) begin nxt = S_IDLE; errNxt = ERR_PREC; end
          else begin strb.hdrQ = 1'b1; strb.idxClr = 1'b1; nxt = S_QBODY; end
        end
        S_QBODY: if (acc) begin
          strb.wrTbl = 1'b1; strb.idxInc = 1'b1;
          if (st.idx == 9'd63) nxt = S_QHDR;
        end
        S_HHDR: if (acc) begin
          strb.hdrH = 1'b1; strb.idxClr = 1'b1; nxt = S_HCNT;
        end
        S_HCNT: if (acc) begin
          strb.wrTbl = 1'b1; strb.idxInc = 1'b1; strb.cntByte = 1'b1;
          if (st.idx == 9'd15)
            nxt = ((st.symLeft + {4'b0, inByte}) == 12'd0) ? S_HHDR : S_HSYM;
        end
        S_HSYM: if (acc) begin
          strb.wrTbl = 1'b1; strb.idxInc = 1'b1; strb.symByte = 1'b1;
          if (st.symLeft == 12'd1) nxt = S_HHDR;
        end
        S_FRAME: if (acc) begin
          if (st.idx == 9'd0 && inByte != 8'd8) begin nxt = S_IDLE; errNxt = ERR_FRAME; end
          else begin strb.frmByte = 1'b1; strb.idxInc = 1'b1; end
        end
        default: ;
      endcase
      if (acc && body) begin
        strb.useByte = 1'b1;
        if (st.lastByte && nxt != S_IDLE) nxt = (kind == K_SCAN) ? S_HAND : S_SEEK;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state <= S_IDLE; kind <= K_SKIP; errCode <= ERR_NONE; doneOut <= 1'b0;
    end else begin
      state <= nxt; kind <= kindNxt; errCode <= errNxt; doneOut <= doneNxt;
    end
  end

  // R9
  handoffNoRead_chk: assert property (@(posedge clk) disable iff (!rstN)
    scanOwn |-> !inReady);
  // R10
  donePulse_chk: assert property (@(posedge clk) disable iff (!rstN)
    doneOut |=> !doneOut);
  // R2
  errIdle_chk: assert property (@(posedge clk) disable iff (!rstN)
    (errCode != ERR_NONE) |-> !inReady);
  // R4
  noUnderflow_chk: assert property (@(posedge clk) disable iff (!rstN)
    (acc && state == S_SKIP) |-> !st.remZero);

endmodule

// File: rtl/jpegMarkerParser.sv
module jpegMarkerParser
  import jpegParsePkg::*;
#(
  parameter int NCOMP = 4
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               startIn,
  input  logic [7:0]         inData,
  input  logic               inValid,
  output logic               inReady,
  output logic               scanOwn,
  input  logic               scanDone,
  output logic               doneOut,
  output logic [1:0]         errCode,
  output logic               tblWrEn,
  output logic               tblWrHuff,
  output logic               tblWrCls,
  output logic [1:0]         tblWrId,
  output logic [8:0]         tblWrAddr,
  output logic [7:0]         tblWrData,
  output logic [15:0]        frmHeight,
  output logic [15:0]        frmWidth,
  output logic [7:0]         frmComps,
  output logic [NCOMP*8-1:0] compSamp,
  output logic [NCOMP*2-1:0] compQsel
);
  ctlStrb_t strb;
  dpStat_t  st;

  parserCtl ctl_i (
    .clk(clk), .rstN(rstN), .startIn(startIn), .inValid(inValid), .inByte(inData),
    .scanDone(scanDone), .st(st), .inReady(inReady), .scanOwn(scanOwn),
    .doneOut(doneOut), .errCode(errCode), .strb(strb)
  );

  parserDp #(.NCOMP(NCOMP)) dp_i (
    .clk(clk), .rstN(rstN), .inByte(inData), .strb(strb), .st(st),
    .tblWrEn(tblWrEn), .tblWrHuff(tblWrHuff), .tblWrCls(tblWrCls), .tblWrId(tblWrId),
    .tblWrAddr(tblWrAddr), .tblWrData(tblWrData), .frmHeight(frmHeight),
    .frmWidth(frmWidth), .frmComps(frmComps), .compSamp(compSamp), .compQsel(compQsel)
  );

endmodule

// File: tb/jpegMarkerParser_tb.sv
module jpegMarkerParser_tb_top;
  localparam int NCOMP = 4;

  logic clk = 1'b0, rstN = 1'b0, startIn = 1'b0, inValid = 1'b0, scanDone = 1'b0;
  logic [7:0] inData = '0;
  logic inReady, scanOwn, doneOut, tblWrEn, tblWrHuff, tblWrCls;
  logic [1:0] errCode, tblWrId;
  logic [8:0] tblWrAddr;
  logic [7:0] tblWrData, frmComps;
  logic [15:0] frmHeight, frmWidth;
  logic [NCOMP*8-1:0] compSamp;
  logic [NCOMP*2-1:0] compQsel;

  int errors = 0, checks = 0;

  always #5 clk = ~clk;

  jpegMarkerParser #(.NCOMP(NCOMP)) dut_i (.*);

  function automatic logic [18:0] nw(input logic [7:0] d);
    return {2'b00, 9'd0, d};
  endfunction
  function automatic logic [18:0] wh(input int a, input logic [7:0] d);
    return {2'b11, 9'(a), d};
  endfunction

  // {expect write, expect code table, expected addr, byte}
  localparam int NV = 55;
  localparam logic [18:0] VEC [NV] = '{
    nw(8'hFF), nw(8'hD8), nw(8'h55),
    nw(8'hFF), nw(8'hFF), nw(8'hE0), nw(8'h00), nw(8'h04), nw(8'hFF), nw(8'hD9),
    nw(8'hFF), nw(8'hD3),
    nw(8'hFF), nw(8'hC4), nw(8'h00), nw(8'h16), nw(8'h10),
    wh(0, 8'h00), wh(1, 8'h02), wh(2, 8'h01), wh(3, 8'h00), wh(4, 8'h00), wh(5, 8'h00),
    wh(6, 8'h00), wh(7, 8'h00), wh(8, 8'h00), wh(9, 8'h00), wh(10, 8'h00), wh(11, 8'h00),
    wh(12, 8'h00), wh(13, 8'h00), wh(14, 8'h00), wh(15, 8'h00),
    wh(16, 8'hA1), wh(17, 8'hB2), wh(18, 8'hC3),
    nw(8'hFF), nw(8'hC0), nw(8'h00), nw(8'h11), nw(8'h08), nw(8'h00), nw(8'h10),
    nw(8'h00), nw(8'h20), nw(8'h03),
    nw(8'h01), nw(8'h22), nw(8'h00), nw(8'h02), nw(8'h11), nw(8'h01),
    nw(8'h03), nw(8'h11), nw(8'h01)
  };

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic send(input logic [7:0] b);
    inData = b; inValid = 1'b1;
    while (!inReady) @(negedge clk);
    @(negedge clk);
    inValid = 1'b0;
  endtask

  task automatic startPulse();
    startIn = 1'b1;
    @(negedge clk);
    startIn = 1'b0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog: actual=hung expected=finish");
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R1 reset state and no intake without start
    chk("R1 ready", inReady, 0);
    chk("R1 err", errCode, 0);
    chk("R1 own", scanOwn, 0);
    inValid = 1'b1; inData = 8'hFF;
    repeat (3) @(negedge clk);
    chk("R1 no write", tblWrEn, 0);
    chk("R1 still idle", inReady, 0);
    inValid = 1'b0;

    // vector walk: R3 fill/standalone, R4 skip, R6 code table, R11 write timing
    startPulse();
    for (int i = 0; i < NV; i++) begin
      send(VEC[i][7:0]);
      chk("R11 wrEn", tblWrEn, VEC[i][18]);
      if (VEC[i][18]) begin
        chk("R6 addr", tblWrAddr, VEC[i][16:8]);
        chk("R6 data", tblWrData, VEC[i][7:0]);
        chk("R6 kind", tblWrHuff, VEC[i][17]);
        chk("R6 class", tblWrCls, 1);
      end
      chk("R4 no done", doneOut, 0);
      chk("R3 no err", errCode, 0);
    end
    @(negedge clk);
    chk("R11 one cycle", tblWrEn, 0);
    // R7 frame fields
    chk("R7 height", frmHeight, 16'h0010);
    chk("R7 width", frmWidth, 16'h0020);
    chk("R7 comps", frmComps, 3);
    chk("R7 samp", compSamp, 32'h0011_1122);
    chk("R7 qsel", compQsel, 8'h14);

    // R5 two quantization tables in one segment
    send(8'hFF); send(8'hDB); send(8'h00); send(8'h84);
    for (int t = 0; t < 2; t++) begin
      send(8'(t));
      chk("R5 hdr no write", tblWrEn, 0);
      for (int k = 0; k < 64; k++) begin
        send(8'(k * 3 + t));
        chk("R5 wrEn", tblWrEn, 1);
        chk("R5 kind", tblWrHuff, 0);
        chk("R5 id", tblWrId, t);
        chk("R5 addr", tblWrAddr, k);
        chk("R5 data", tblWrData, (k * 3 + t) & 8'hFF);
      end
    end

    // R9 scan handoff
    send(8'hFF); send(8'hDA); send(8'h00); send(8'h08);
    for (int k = 0; k < 6; k++) send(8'h01);
    chk("R9 own", scanOwn, 1);
    chk("R9 not ready", inReady, 0);
    inValid = 1'b1; inData = 8'hFF;
    repeat (3) @(negedge clk);
    chk("R9 held", scanOwn, 1);
    inValid = 1'b0;
    scanDone = 1'b1; @(negedge clk); scanDone = 1'b0;
    chk("R9 released", scanOwn, 0);
    chk("R9 ready again", inReady, 1);
    send(8'h77);
    send(8'hFF); send(8'hD9);
    // R10 end of image
    chk("R10 done", doneOut, 1);
    chk("R10 err", errCode, 0);
    @(negedge clk);
    chk("R10 pulse", doneOut, 0);
    chk("R1 idle after done", inReady, 0);

    // R2 bad start markers
    startPulse();
    send(8'h12);
    chk("R2 first byte", errCode, 1);
    chk("R2 idle", inReady, 0);
    startPulse();
    chk("R12 clears err", errCode, 0);
    send(8'hFF); send(8'hD9);
    chk("R2 second byte", errCode, 1);

    // R8 unsupported frame
    startPulse();
    send(8'hFF); send(8'hD8); send(8'hFF); send(8'hC2);
    chk("R8 unsupported", errCode, 2);
    chk("R8 idle", inReady, 0);

    // R5 bad precision
    startPulse();
    send(8'hFF); send(8'hD8); send(8'hFF); send(8'hDB); send(8'h00); send(8'h43); send(8'h10);
    chk("R5 precision", errCode, 3);

    // R7 bad frame precision
    startPulse();
    send(8'hFF); send(8'hD8); send(8'hFF); send(8'hC0); send(8'h00); send(8'h0B); send(8'h0C);
    chk("R7 precision", errCode, 2);

    // R12 restart mid-segment
    startPulse();
    send(8'hFF); send(8'hD8); send(8'hFF); send(8'hE1); send(8'h00); send(8'h10); send(8'h11);
    startPulse();
    send(8'hFF); send(8'hD8); send(8'hFF); send(8'hD9);
    chk("R12 restart done", doneOut, 1);
    chk("R12 restart err", errCode, 0);

    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule